// File: doc/BRIEF.md
# One-Time-Programmable Fuse Word Controller

This block puts a bank of one-time-programmable fuses, arranged as 32-bit words, behind a simple memory-mapped register interface. Software selects a word with an address register and a bit with a bit-select register, places the value to burn in a data register, and then writes the write-enable register to program that single bit. A whole fuse word is read back through a read-only data port, but only while the chip-enable, strobe and trim controls are all switched on; otherwise that port returns 0xFF.

Each fuse bit may be burned once. A per-bit history map records every programmed bit, and any later attempt on the same bit is refused without touching the fuse, setting a sticky error flag. A nonzero redundancy-select value suppresses programming altogether. After reset every word reads all ones, except for a configured serial number and its bitwise complement stored in two adjacent words. The remaining control registers (clocking, program pulse, test controls) are plain read/write storage.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: Registers are 32 bits, selected by word offset `bus_addr[5:2]`: 0 address, 1 bit select, 2 data in, 3 data out, 4 chip enable, 5 strobe, 6 trim, 7 redundancy select, 8 write enable, 9 program pulse, 10 clock control, 11 to 13 test controls. Registers 1, 2, 4 to 7 and 9 to 13 read back the full written value. A read issued in one cycle returns `bus_rdata` with `bus_rvalid` high in the next cycle. Offsets 14 and 15 read as zero and ignore writes.
- R2: The address register keeps only its low ADDR_W bits (8 by default), so writing 0xFFFFFFFF reads back 0x000000FF.
- R3: A read of the data-out register returns the fuse word selected by the address register when bit 0 of chip enable, strobe and trim are all 1; if any of them is 0 it returns 0x000000FF.
- R4: Writes to the data-out register change no fuse and no register.
- R5: The write-enable register stores only bit 0 of the written value; the other bits read as zero.
- R6: A write to write enable with bit 0 set, while redundancy select is zero, sets fuse bit `bitsel[4:0]` of the addressed word to data-in bit 0 (1 sets it, 0 clears it) and marks that bit as burned; the new word is readable from the following cycle.
- R7: While redundancy select is nonzero, a write-enable write programs nothing and marks nothing, so the same bit can be programmed later with redundancy select at zero.
- R8: A program request on a bit already burned leaves the fuse word unchanged and sets `wo_err`, which stays set until reset.
- R9: After reset all words read 0xFFFFFFFF except word SERIAL_IDX (252), which holds SERIAL_NUM (0x12345678), and word SERIAL_IDX+1, which holds its complement; no bit is marked as burned, `wo_err` is 0 and all registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access request for this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| wo_err | output | 1 | Sticky flag: a program request hit an already burned bit |

## Verification
A corrupted fuse word or a missed update shows in the data-out value of the very next read of that word, one cycle after the read request. A wrong burned-bit map shows only when the same bit is programmed again: a map that never marks lets the second request change the word and leaves `wo_err` low, while a map that marks under redundancy select rejects a later legitimate program. Gating faults on the three enables show as a word where 0xFF belongs, or the reverse, on the first gated read.

// File: rtl/otp_pkg.sv
package otp_pkg;
  localparam int REG_W   = 32;
  localparam int IDX_W   = 4;
  localparam int NREG    = 14;
  localparam int R_ADDR  = 0;
  localparam int R_BSEL  = 1;
  localparam int R_DIN   = 2;
  localparam int R_DOUT  = 3;
  localparam int R_CE    = 4;
  localparam int R_STB   = 5;
  localparam int R_TRIM  = 6;
  localparam int R_REDUN = 7;
  localparam int R_WREN  = 8;
  localparam int R_PROG  = 9;
  localparam int R_CLK   = 10;
  localparam int R_TMODE = 11;
  localparam int R_TREP  = 12;
  localparam int R_TCTL  = 13;
  localparam logic [REG_W-1:0] GATED_READ = 32'h0000_00FF;
endpackage

// File: rtl/otp_regfile.sv
module otp_regfile
  import otp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BUS_AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              bus_rvalid,
  input  logic [REG_W-1:0]  fuse_word,
  output logic [ADDR_W-1:0] word_sel,
  output logic [4:0]        bit_sel,
  output logic              bit_val,
  output logic              prog_req
);
  localparam int WIDX = BUS_AW - 2;

  logic [REG_W-1:0] regs_q [NREG];
  logic [REG_W-1:0] regs_d [NREG];
  logic [REG_W-1:0] rdata_q, rdata_d;
  logic             rvalid_q, rvalid_d;
  logic [WIDX-1:0]  idx;
  logic             wr_hit, rd_hit, rd_open;

  function automatic logic [REG_W-1:0] wmask(input int i);
    if (i == R_DOUT)      return '0;
    else if (i == R_ADDR) return REG_W'((64'd1 << ADDR_W) - 1);
    else if (i == R_WREN) return REG_W'(1);
    else                  return '1;
  endfunction

  assign idx     = bus_addr[BUS_AW-1:2];
  assign wr_hit  = bus_sel && bus_wr;
  assign rd_hit  = bus_sel && !bus_wr;
  assign rd_open = regs_q[R_CE][0] && regs_q[R_STB][0] && regs_q[R_TRIM][0];

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      regs_d[i] = regs_q[i];
      if (wr_hit && (int'(idx) == i)) regs_d[i] = bus_wdata & wmask(i);
    end
    rvalid_d = rd_hit;
    rdata_d  = rdata_q;
    if (rd_hit) begin
      if (int'(idx) == R_DOUT)   rdata_d = rd_open ? fuse_word : GATED_READ;
      else if (int'(idx) < NREG) rdata_d = regs_q[idx];
      else                       rdata_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= regs_d[i];
      rvalid_q <= rvalid_d;
      if (rd_hit) rdata_q <= rdata_d;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;
  assign word_sel   = regs_q[R_ADDR][ADDR_W-1:0];
  assign bit_sel    = regs_q[R_BSEL][4:0];
  assign bit_val    = regs_q[R_DIN][0];
  assign prog_req   = wr_hit && (int'(idx) == R_WREN) && bus_wdata[0] &&
                      (regs_q[R_REDUN] == '0);

  assert_rvalid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> $past(bus_sel && !bus_wr));

  assert_dout_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && (int'(idx) == R_DOUT) && !rd_open) |=> (bus_rdata == GATED_READ));

  assert_redun_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (regs_q[R_REDUN] != '0) |-> !prog_req);
endmodule

// File: rtl/otp_fuse_bank.sv
module otp_fuse_bank
  import otp_pkg::*;
#(
  parameter int               ADDR_W     = 8,
  parameter int               SERIAL_IDX = 252,
  parameter logic [REG_W-1:0] SERIAL_NUM = 32'h1234_5678
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_req,
  input  logic [ADDR_W-1:0] word_sel,
  input  logic [4:0]        bit_sel,
  input  logic              bit_val,
  output logic [REG_W-1:0]  fuse_word,
  output logic              wo_err
);
  localparam int WORDS = 1 << ADDR_W;

  logic [REG_W-1:0] fuse_q  [WORDS];
  logic [REG_W-1:0] burnt_q [WORDS];
  logic [REG_W-1:0] word_d, mark_d;
  logic             already, wr_en, err_q, err_d;

  always_comb begin
    already = burnt_q[word_sel][bit_sel];
    wr_en   = prog_req && !already;
    word_d  = fuse_q[word_sel];
    word_d[bit_sel] = bit_val;
    mark_d  = burnt_q[word_sel];
    mark_d[bit_sel] = 1'b1;
    err_d   = err_q || (prog_req && already);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) begin
        if (i == SERIAL_IDX)          fuse_q[i] <= SERIAL_NUM;
        else if (i == SERIAL_IDX + 1) fuse_q[i] <= ~SERIAL_NUM;
        else                          fuse_q[i] <= '1;
        burnt_q[i] <= '0;
      end
      err_q <= 1'b0;
    end else begin
      if (wr_en) begin
        fuse_q[word_sel]  <= word_d;
        burnt_q[word_sel] <= mark_d;
      end
      err_q <= err_d;
    end
  end

  assign fuse_word = fuse_q[word_sel];
  assign wo_err    = err_q;

  assert_reject_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_req && already) |=> (fuse_q[$past(word_sel)] == $past(fuse_word)));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wo_err |=> wo_err);

  assert_mark_after_prog_R6: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |=> burnt_q[$past(word_sel)][$past(bit_sel)]);
endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
  import otp_pkg::*;
#(
  parameter int               ADDR_W     = 8,
  parameter int               BUS_AW     = 6,
  parameter int               SERIAL_IDX = 252,
  parameter logic [REG_W-1:0] SERIAL_NUM = 32'h1234_5678
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic              wo_err
);
  logic [1:0]        rst_pipe_q;
  logic              rst_int_n;
  logic [REG_W-1:0]  fuse_word;
  logic [ADDR_W-1:0] word_sel;
  logic [4:0]        bit_sel;
  logic              bit_val, prog_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  otp_regfile #(.ADDR_W(ADDR_W), .BUS_AW(BUS_AW)) u_regs (
    .clk(clk), .rst_n(rst_int_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .fuse_word(fuse_word), .word_sel(word_sel), .bit_sel(bit_sel),
    .bit_val(bit_val), .prog_req(prog_req)
  );

  otp_fuse_bank #(.ADDR_W(ADDR_W), .SERIAL_IDX(SERIAL_IDX),
                  .SERIAL_NUM(SERIAL_NUM)) u_bank (
    .clk(clk), .rst_n(rst_int_n),
    .prog_req(prog_req), .word_sel(word_sel), .bit_sel(bit_sel),
    .bit_val(bit_val), .fuse_word(fuse_word), .wo_err(wo_err)
  );
endmodule

// File: tb/tb_otp_fuse_ctrl.sv
module tb_otp_fuse_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        wo_err;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  localparam int O_ADDR = 0, O_BSEL = 4, O_DIN = 8, O_DOUT = 12, O_CE = 16,
                 O_STB = 20, O_TRIM = 24, O_REDUN = 28, O_WREN = 32, O_CLK = 40,
                 O_TCTL = 52, O_HOLE = 56;
  localparam logic [31:0] SER = 32'h1234_5678;

  otp_fuse_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .wo_err(wo_err)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input int off, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 6'(off); bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input int off, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 6'(off);
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rvalid ? bus_rdata : 32'hDEAD_BEEF;
  endtask

  task automatic read_word(input int a, output logic [31:0] d);
    wr(O_ADDR, 32'(a));
    rd(O_DOUT, d);
  endtask

  task automatic program_bit(input int a, input int b, input bit v);
    wr(O_ADDR, 32'(a));
    wr(O_BSEL, 32'(b));
    wr(O_DIN, {31'd0, v});
    wr(O_WREN, 32'h1);
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    check("R9 wo_err after reset", {31'd0, wo_err}, 32'h0);
    rd(O_CE, d);   check("R9 chip enable reset", d, 32'h0);
    rd(O_DOUT, d); check("R3 gated read with enables off", d, 32'hFF);
    wr(O_CE, 1); wr(O_STB, 1); wr(O_TRIM, 1);
    read_word(0, d);   check("R9 plain word all ones", d, 32'hFFFF_FFFF);
    read_word(252, d); check("R9 serial word", d, SER);
    read_word(253, d); check("R9 serial complement", d, ~SER);
  endtask

  task automatic t_gating();
    logic [31:0] d;
    wr(O_ADDR, 252);
    wr(O_TRIM, 0); rd(O_DOUT, d); check("R3 trim off", d, 32'hFF);
    wr(O_TRIM, 1); wr(O_STB, 32'hFFFF_FFFE); rd(O_DOUT, d); check("R3 strobe bit0 off", d, 32'hFF);
    wr(O_STB, 1); rd(O_DOUT, d); check("R3 all enables on", d, SER);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(O_ADDR, 32'hFFFF_FFFF); rd(O_ADDR, d); check("R2 address mask", d, 32'hFF);
    wr(O_CLK, 32'hA5C3_0F01); rd(O_CLK, d); check("R1 clock ctl readback", d, 32'hA5C3_0F01);
    wr(O_TCTL, 32'h8000_0002); rd(O_TCTL, d); check("R1 test ctl readback", d, 32'h8000_0002);
    wr(O_HOLE, 32'h1234_5678); rd(O_HOLE, d); check("R1 unmapped reads zero", d, 32'h0);
  endtask

  task automatic t_program();
    logic [31:0] d;
    program_bit(5, 3, 1'b0);
    read_word(5, d); check("R6 clear bit 3", d, 32'hFFFF_FFF7);
    program_bit(6, 32'h27, 1'b0);
    read_word(6, d); check("R6 bit select masked to 5 bits", d, 32'hFFFF_FF7F);
    check("R8 no error on first burns", {31'd0, wo_err}, 32'h0);
    program_bit(5, 3, 1'b1);
    read_word(5, d); check("R8 second burn rejected", d, 32'hFFFF_FFF7);
    check("R8 error flag set", {31'd0, wo_err}, 32'h1);
  endtask

  task automatic t_dout_ro();
    logic [31:0] d;
    wr(O_ADDR, 5);
    wr(O_DOUT, 32'h0);
    rd(O_DOUT, d); check("R4 data-out write ignored", d, 32'hFFFF_FFF7);
    rd(O_ADDR, d); check("R4 address untouched", d, 32'h5);
  endtask

  task automatic t_redundancy();
    logic [31:0] d;
    wr(O_REDUN, 1);
    program_bit(7, 0, 1'b0);
    read_word(7, d); check("R7 no program under redundancy", d, 32'hFFFF_FFFF);
    wr(O_WREN, 32'hFFFF_FFFF); rd(O_WREN, d); check("R5 write enable keeps bit0", d, 32'h1);
    wr(O_WREN, 32'hFFFF_FFFE); rd(O_WREN, d); check("R5 write enable bit0 clear", d, 32'h0);
    wr(O_REDUN, 0);
    program_bit(7, 0, 1'b0);
    read_word(7, d); check("R7 later program succeeds", d, 32'hFFFF_FFFE);
    check("R8 error stays set", {31'd0, wo_err}, 32'h1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_state();
    t_gating();
    t_regs();
    t_program();
    t_dout_ro();
    t_redundancy();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule